// File: doc/BRIEF.md
# Scheduled Tile Crossbar Switch

This block is the switch of one tile in a mesh of processing tiles. It takes words from four neighbour links (north, south, east, west) and from the local core, and passes them to the four outgoing links and to the core. Routing does not use packet headers or arbitration. A schedule computed before run time is loaded into a small instruction store. While the switch runs, a program counter steps through that store one entry per clock. Each entry sets the crossbar for that cycle, and any source may feed several outputs at once.

Traffic between the core and the mesh passes through two small buffers. The core fills an injection buffer that the schedule drains onto the links. The schedule fills an ejection buffer that the core reads. The schedule is loaded through a plain write port while the run enable is low. Each outgoing link is registered, so a hop costs one clock.

Top module: `tile_switch`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all link output valids are low, `core_rx_valid` is low, `rx_overflow` is low and `core_tx_full` is low. Reset also clears every schedule entry to all-idle and returns the program counter to entry 0.
- R2: A schedule entry holds one 4-bit field per output, with output o at bits [4o+3:4o] and the outputs numbered north 0, south 1, east 2, west 3, core 4. Bit 4o+3 enables the output. Bits [4o+2:4o] name the source: 0 north, 1 south, 2 east, 3 west, 4 core injection buffer. The selected source's data and valid appear on a link output on the clock edge that executes the entry.
- R3: An output whose field has the enable bit at 0, or a source code of 5, 6 or 7, drives its valid low for that cycle.
- R4: A single source named in several fields of one entry reaches all of those outputs in the same cycle.
- R5: While `run_en` is high, the entry executed advances by one each clock from 0 up to `sched_last`, then wraps to 0. The first edge with `run_en` high executes entry 0.
- R6: While `run_en` is low, every link output valid is low and the program counter stays at 0. A `cfg_we` write stores `cfg_data` at `cfg_addr` only while `run_en` is low. A write while running is ignored.
- R7: A link output that selects the core source carries the head of the injection buffer with valid high when the buffer holds a word, and carries valid low when it is empty. An entry removes at most one word from the buffer, however many outputs select it.
- R8: When the core field selects a source whose valid is high, that word is appended to a 4-entry ejection buffer. `core_rx_data` shows the oldest word, `core_rx_valid` is high while the buffer is not empty, and `core_rd_en` removes one word.
- R9: A word routed to the core while the ejection buffer holds 4 words is dropped and sets `rx_overflow`. The flag stays set until reset.
- R10: `core_tx_full` is high while the injection buffer holds 4 words. A `core_wr_en` write while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run the schedule; low allows configuration |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_addr | input | 4 | Schedule entry index |
| cfg_data | input | 20 | Schedule entry contents |
| sched_last | input | 4 | Index of the last entry before wrap |
| link_in_data | input | 64 | Incoming words, north at [15:0], then south, east, west |
| link_in_valid | input | 4 | Incoming valids, bit 0 north to bit 3 west |
| link_out_data | output | 64 | Registered outgoing words, same packing |
| link_out_valid | output | 4 | Registered outgoing valids |
| core_wr_en | input | 1 | Core pushes a word into the injection buffer |
| core_wr_data | input | 16 | Word from the core |
| core_tx_full | output | 1 | Injection buffer full |
| core_rd_en | input | 1 | Core pops the ejection buffer |
| core_rx_data | output | 16 | Oldest ejected word |
| core_rx_valid | output | 1 | Ejection buffer not empty |
| rx_overflow | output | 1 | Sticky drop flag of the ejection buffer |

## Verification
A program counter that steps wrongly shows at the link outputs on the very next edge, because the wrong entry routes the wrong source or leaves a valid low where a word was due. A miscounted injection buffer shows up one schedule round later. Either a word repeats on the outputs, or a valid stays high after the buffer should have run dry. Ejection errors stay hidden while the switch runs. They appear when the core drains the buffer: a word is missing, or the order is wrong, or the overflow flag is wrong.

// File: rtl/tile_switch_pkg.sv
package tile_switch_pkg;
   localparam int NUM_LINKS = 4;
   localparam int NUM_PORTS = 5;
   localparam int FLD_W     = 4;
   localparam int INSTR_W   = NUM_PORTS * FLD_W;

   typedef enum logic [2:0] {
      SRC_NORTH = 3'd0,
      SRC_SOUTH = 3'd1,
      SRC_EAST  = 3'd2,
      SRC_WEST  = 3'd3,
      SRC_CORE  = 3'd4
   } src_sel_e;
endpackage

// File: rtl/ts_fifo.sv
module ts_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) begin
            mem[wp] <= din;
            wp      <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
         end
         if (do_pop)
            rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/ts_sched.sv
module ts_sched #(
   parameter int DEPTH   = 16,
   parameter int INSTR_W = 20,
   localparam int PCW    = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               cfg_we,
   input  logic [PCW-1:0]     cfg_addr,
   input  logic [INSTR_W-1:0] cfg_data,
   input  logic [PCW-1:0]     sched_last,
   output logic [PCW-1:0]     pc,
   output logic [INSTR_W-1:0] instr
);
   logic [INSTR_W-1:0] store [DEPTH];

   assign instr = store[pc];

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc <= '0;
      else if (!run_en)
         pc <= '0;
      else
         pc <= (pc == sched_last) ? '0 : pc + 1'b1;
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            store[e] <= '0;
         else if (cfg_we && !run_en && cfg_addr == PCW'(e))
            store[e] <= cfg_data;
      end
   end
endmodule

// File: rtl/ts_xbar.sv
module ts_xbar
   import tile_switch_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [INSTR_W-1:0]     instr,
   input  logic [NUM_PORTS*W-1:0] src_data,
   input  logic [NUM_PORTS-1:0]   src_valid,
   output logic [NUM_PORTS*W-1:0] dst_data,
   output logic [NUM_PORTS-1:0]   dst_valid,
   output logic                   core_pop
);
   logic [NUM_PORTS-1:0] uses_core;

   for (genvar d = 0; d < NUM_PORTS; d++) begin : g_dst
      logic [FLD_W-1:0] fld;
      logic [2:0]       sel;
      logic             hit;
      assign fld = instr[d*FLD_W +: FLD_W];
      assign sel = fld[2:0];
      assign hit = fld[3] && (int'(sel) < NUM_PORTS);
      always_comb begin
         dst_data[d*W +: W] = '0;
         dst_valid[d]       = 1'b0;
         if (hit) begin
            dst_data[d*W +: W] = src_data[int'(sel)*W +: W];
            dst_valid[d]       = src_valid[int'(sel)];
         end
      end
      assign uses_core[d] = hit && (sel == SRC_CORE);
   end

   assign core_pop = |uses_core;
endmodule

// File: rtl/tile_switch.sv
module tile_switch
   import tile_switch_pkg::*;
#(
   parameter int LINK_W      = 16,
   parameter int SCHED_DEPTH = 16,
   parameter int FIFO_DEPTH  = 4,
   localparam int PCW        = $clog2(SCHED_DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_en,
   input  logic                        cfg_we,
   input  logic [PCW-1:0]              cfg_addr,
   input  logic [INSTR_W-1:0]          cfg_data,
   input  logic [PCW-1:0]              sched_last,
   input  logic [NUM_LINKS*LINK_W-1:0] link_in_data,
   input  logic [NUM_LINKS-1:0]        link_in_valid,
   output logic [NUM_LINKS*LINK_W-1:0] link_out_data,
   output logic [NUM_LINKS-1:0]        link_out_valid,
   input  logic                        core_wr_en,
   input  logic [LINK_W-1:0]           core_wr_data,
   output logic                        core_tx_full,
   input  logic                        core_rd_en,
   output logic [LINK_W-1:0]           core_rx_data,
   output logic                        core_rx_valid,
   output logic                        rx_overflow
);
   if (SCHED_DEPTH < 2 || (SCHED_DEPTH & (SCHED_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("SCHED_DEPTH must be a power of two of at least 2");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (LINK_W < 1) begin : g_bad_width
      $error("LINK_W must be positive");
   end

   logic [PCW-1:0]              pc;
   logic [INSTR_W-1:0]          instr;
   logic [NUM_PORTS*LINK_W-1:0] dst_data;
   logic [NUM_PORTS-1:0]        dst_valid;
   logic                        core_pop;
   logic [LINK_W-1:0]           tx_head;
   logic                        tx_empty, rx_empty, rx_full, rx_push;

   ts_sched #(.DEPTH(SCHED_DEPTH), .INSTR_W(INSTR_W)) u_sched (
      .clk, .rst_n, .run_en, .cfg_we, .cfg_addr, .cfg_data, .sched_last,
      .pc(pc), .instr(instr)
   );

   ts_xbar #(.W(LINK_W)) u_xbar (
      .instr(instr),
      .src_data({tx_head, link_in_data}),
      .src_valid({!tx_empty, link_in_valid}),
      .dst_data(dst_data),
      .dst_valid(dst_valid),
      .core_pop(core_pop)
   );

   ts_fifo #(.W(LINK_W), .DEPTH(FIFO_DEPTH)) u_tx (
      .clk, .rst_n,
      .push(core_wr_en), .din(core_wr_data),
      .pop(run_en && core_pop), .dout(tx_head),
      .empty(tx_empty), .full(core_tx_full)
   );

   assign rx_push = run_en && dst_valid[NUM_LINKS];

   ts_fifo #(.W(LINK_W), .DEPTH(FIFO_DEPTH)) u_rx (
      .clk, .rst_n,
      .push(rx_push), .din(dst_data[NUM_LINKS*LINK_W +: LINK_W]),
      .pop(core_rd_en), .dout(core_rx_data),
      .empty(rx_empty), .full(rx_full)
   );

   assign core_rx_valid = !rx_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_out_data  <= '0;
         link_out_valid <= '0;
         rx_overflow    <= 1'b0;
      end else begin
         if (run_en) begin
            link_out_data  <= dst_data[NUM_LINKS*LINK_W-1:0];
            link_out_valid <= dst_valid[NUM_LINKS-1:0];
         end else begin
            link_out_valid <= '0;
         end
         if (rx_push && rx_full)
            rx_overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/tile_switch_chk.sv
module tile_switch_chk #(
   parameter int PCW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           run_en,
   input logic [PCW-1:0] sched_last,
   input logic [PCW-1:0] pc,
   input logic [3:0]     link_out_valid,
   input logic           core_rx_valid,
   input logic           core_rd_en,
   input logic           rx_overflow
);
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (link_out_valid == '0 && !core_rx_valid && !rx_overflow));

   a_r5_pc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && pc == sched_last) |=> (pc == '0));

   a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && pc != sched_last) |=> (pc == PCW'($past(pc) + 1'b1)));

   a_r6_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (link_out_valid == '0 && pc == '0));

   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |=> rx_overflow);

   a_r8_rx_drain_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rx_valid) |-> $past(core_rd_en));
endmodule

bind tile_switch tile_switch_chk #(.PCW(PCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .sched_last(sched_last),
   .pc(pc), .link_out_valid(link_out_valid), .core_rx_valid(core_rx_valid),
   .core_rd_en(core_rd_en), .rx_overflow(rx_overflow)
);

// File: tb/tile_switch_tb.sv
`timescale 1ns/1ps
module tile_switch_tb;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [19:0] cfg_data = '0;
   logic [3:0]  sched_last = '0;
   logic [63:0] link_in_data = '0;
   logic [3:0]  link_in_valid = '0;
   logic [63:0] link_out_data;
   logic [3:0]  link_out_valid;
   logic        core_wr_en = 1'b0;
   logic [15:0] core_wr_data = '0;
   logic        core_tx_full;
   logic        core_rd_en = 1'b0;
   logic [15:0] core_rx_data;
   logic        core_rx_valid;
   logic        rx_overflow;

   always #2.5 clk = ~clk;

   tile_switch u_dut (.*);

   typedef struct {
      logic [3:0]  valid;
      logic [63:0] data;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [15:0] tx_m[$];
   logic [15:0] rx_m[$];
   logic [19:0] prog_m [16];
   int          pc_m = 0;
   logic        ovf_m = 1'b0;
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] fld(input int src, input bit en);
      return {en, 3'(src)};
   endfunction

   // Scoreboard monitor: compares registered link outputs one edge after each step
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(link_out_valid == e.valid, e.tag, "link valid",
               64'(link_out_valid), 64'(e.valid));
         for (int d = 0; d < 4; d++)
            if (e.valid[d])
               check(link_out_data[d*W +: W] == e.data[d*W +: W], e.tag, "link data",
                     64'(link_out_data[d*W +: W]), 64'(e.data[d*W +: W]));
      end
   end

   task automatic cfg_write(input int addr, input logic [19:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = val;
      if (!run_en) prog_m[addr] = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Driver: applies one scheduled cycle and pushes the expected link outputs
   task automatic run_step(input logic [3:0] vin, input string tag);
      exp_t        e;
      logic [19:0] ins;
      logic [15:0] src_d [4];
      bit          tx_av, used_core;
      @(negedge clk);
      run_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         src_d[s] = 16'((s + 1) * 16'h1000 + cyc);
         link_in_data[s*W +: W] = src_d[s];
      end
      link_in_valid = vin;
      ins = prog_m[pc_m];
      tx_av = tx_m.size() > 0;
      used_core = 1'b0;
      e.valid = '0; e.data = '0; e.tag = tag;
      for (int d = 0; d < 5; d++) begin
         logic [3:0]  f;
         logic        v;
         logic [15:0] dv;
         f = ins[d*4 +: 4];
         v = 1'b0; dv = '0;
         if (f[3] && f[2:0] < 3'd5) begin
            if (f[2:0] == 3'd4) begin
               used_core = 1'b1; v = tx_av; dv = tx_av ? tx_m[0] : '0;
            end else begin
               v = vin[f[2:0]]; dv = src_d[f[2:0]];
            end
         end
         if (d < 4) begin
            e.valid[d] = v; e.data[d*W +: W] = dv;
         end else if (v) begin
            if (rx_m.size() == 4) ovf_m = 1'b1;
            else rx_m.push_back(dv);
         end
      end
      if (used_core && tx_av) void'(tx_m.pop_front());
      pc_m = (pc_m == int'(sched_last)) ? 0 : pc_m + 1;
      @(posedge clk);
      #1;
      exp_q.push_back(e);
      cyc++;
   endtask

   task automatic idle_step();
      exp_t e;
      @(negedge clk);
      run_en = 1'b0;
      pc_m = 0;
      e.valid = '0; e.data = '0; e.tag = "R6";
      @(posedge clk);
      #1;
      exp_q.push_back(e);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) prog_m[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs idle under reset
      check(link_out_valid == 0, "R1", "link valid in reset", 64'(link_out_valid), 0);
      check(!core_rx_valid && !rx_overflow && !core_tx_full, "R1", "core flags in reset",
            64'({core_rx_valid, rx_overflow, core_tx_full}), 0);
      rst_n = 1'b1;
      sched_last = 4'd3;
      // R2/R4: entry0 north to south and east, west to north
      cfg_write(0, {fld(0, 0), fld(0, 0), fld(0, 1), fld(0, 1), fld(3, 1)});
      // R3: entry1 idle by enable low, and by code 6 with enable high
      cfg_write(1, {fld(0, 0), fld(0, 0), fld(0, 0), fld(6, 1), fld(7, 1)});
      // R7/R8: entry2 core to east, south to core, east to west
      cfg_write(2, {fld(1, 1), fld(2, 1), fld(4, 1), fld(0, 0), fld(0, 0)});
      // R4/R7: entry3 core to north and south, north to core
      cfg_write(3, {fld(0, 1), fld(0, 0), fld(0, 0), fld(4, 1), fld(4, 1)});

      // R10: fill injection buffer, fifth write ignored
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         core_wr_en = 1'b1; core_wr_data = 16'(16'hA000 + i);
         if (tx_m.size() < 4) tx_m.push_back(16'(16'hA000 + i));
         @(negedge clk);
         core_wr_en = 1'b0;
         if (i == 3) check(!core_tx_full, "R10", "not full at 3", 64'(core_tx_full), 0);
         if (i >= 4) check(core_tx_full, "R10", "full at 4", 64'(core_tx_full), 1);
      end

      run_step(4'b1110, "R2");   // north invalid this cycle
      run_step(4'b1111, "R3");
      run_step(4'b1111, "R7");
      run_step(4'b1111, "R4");
      run_step(4'b1111, "R5");   // wrapped to entry0
      // R6: write during run is ignored
      cfg_we = 1'b1; cfg_addr = 4'd1; cfg_data = {5{fld(0, 1)}};
      run_step(4'b1111, "R6");
      cfg_we = 1'b0;
      run_step(4'b1011, "R7");   // east invalid
      run_step(4'b1111, "R4");
      run_step(4'b0101, "R5");
      run_step(4'b1111, "R3");
      run_step(4'b1111, "R7");   // injection buffer now empty
      run_step(4'b1111, "R9");
      idle_step();
      idle_step();

      @(negedge clk);
      // R10: fifth write was dropped, so the buffer drained fully
      check(!core_tx_full, "R10", "tx not full after drain", 64'(core_tx_full), 0);
      // R9: overflow sticky
      check(rx_overflow == ovf_m, "R9", "overflow flag", 64'(rx_overflow), 64'(ovf_m));
      // R8: drain ejection buffer in order
      while (rx_m.size() > 0) begin
         logic [15:0] w;
         w = rx_m.pop_front();
         check(core_rx_valid, "R8", "rx valid", 64'(core_rx_valid), 1);
         check(core_rx_data == w, "R8", "rx data", 64'(core_rx_data), 64'(w));
         core_rd_en = 1'b1;
         @(negedge clk);
         core_rd_en = 1'b0;
      end
      check(!core_rx_valid, "R8", "rx empty after drain", 64'(core_rx_valid), 0);
      check(rx_overflow, "R9", "overflow still set", 64'(rx_overflow), 1);

      // R5/R6: restart runs entry0 then untouched entry1
      run_step(4'b1111, "R5");
      run_step(4'b1111, "R6");
      idle_step();
      @(negedge clk);
      @(negedge clk);

      // R1/R9: reset clears overflow
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!rx_overflow && !core_rx_valid, "R1", "cleared by reset",
            64'({rx_overflow, core_rx_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule